// File: doc/BRIEF.md
# Multicast-Capable Fabric Cell Forwarder

This block is one switching element of a crossbar fabric. Several input links each present one cell at a time, and each cell carries a small header. A unicast cell names a single destination processor in a 7-bit field and is delivered to that output. A multicast cell carries a 16-bit group number. The group number selects an entry in an on-chip group table, and each entry is a bitmap with one bit per output. The cell is copied to every output whose bit is set, and each of those outputs receives exactly one copy.

Each input keeps the cell it holds at its head until every copy that cell owes has been taken by an output register. Outputs that are free take their copy at once, and busy outputs take theirs later. Each output register chooses among the competing inputs in round-robin order. Control software loads the table through a single write port. Several group numbers may point at bitmaps with the same contents. A cell that cannot go anywhere is discarded and added to a drop counter. Such a cell has a unicast destination beyond the last output, a group number beyond the table, or a bitmap with no bits set.

Top module: `fcx_cell_forwarder`

## Requirements
- R1: A unicast cell (`in_mcast`=0) accepted at a clock edge (`in_valid` and `in_ready` both high) appears on output `in_dest` at the next edge. `out_src` holds the input index and `out_data` holds the payload. No output is valid before that edge. `in_group` is ignored for unicast cells.
- R2: A multicast cell (`in_mcast`=1) reads table entry `in_group`. Bit j of that entry set means a copy goes to output j. When all those outputs are free, every copy appears at the edge after acceptance. `in_dest` is ignored for multicast cells.
- R3: Each output named in the bitmap receives exactly one copy of a multicast cell, and outputs not named receive none.
- R4: `tbl_we` high at an edge writes `tbl_map` into entry `tbl_addr`. A cell accepted at that same edge still sees the old entry, and cells accepted later see the new one. Reset clears every entry to zero.
- R5: A multicast cell stays at the head of its input, with `in_ready` low, until every named output has taken its copy. Free outputs take their copies in earlier cycles than busy ones. `in_ready` rises in the same cycle as the last copy is granted.
- R6: Each output grants one input per cycle. The search starts at the input after the one granted last (index wrapping to 0) and takes the first input that is requesting.
- R7: A cell is dropped and produces no copy when it is unicast with `in_dest` >= N_OUT, multicast with `in_group` >= TBL_DEPTH, or multicast with an all-zero entry. `drop_count` rises by the number of cells dropped, at the edge after acceptance, and the input is free again in that cycle.
- R8: While `out_valid` is high and `out_ready` is low, the output holds its valid flag, data and source unchanged.
- R9: After reset, `out_valid` is all zero, `drop_count` is zero and `in_ready` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N_IN | Cell present, one bit per input |
| in_ready | output | N_IN | Input can take a new cell this cycle |
| in_mcast | input | N_IN | 1 = multicast cell, 0 = unicast |
| in_dest | input | N_IN*7 | Unicast destination per input |
| in_group | input | N_IN*16 | Multicast group number per input |
| in_data | input | N_IN*DATA_W | Cell payload per input |
| out_valid | output | N_OUT | Output register holds a cell |
| out_ready | input | N_OUT | Downstream takes the output cell |
| out_data | output | N_OUT*DATA_W | Payload per output |
| out_src | output | N_OUT*SRC_W | Input index the cell came from |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | TBL_AW | Table entry to write |
| tbl_map | input | N_OUT | Destination bitmap to store |
| drop_count | output | CNT_W | Number of cells discarded |

## Verification
Each result of this block falls a fixed number of edges after a stimulus. A copy or a drop-count step lands one edge after the acceptance edge. The table write and a read of the same entry meet at the acceptance edge itself. `in_ready` responds within the same cycle to `out_ready` and to grants. The bench drives on falling edges and records whether each input was accepted just before the rising edge. It then counts rising edges from that point and reads outputs on the falling edge where the result is due. A check one edge earlier confirms nothing arrives early. Copy counts and the round-robin delivery order are gathered from output handshakes, so that duplicate and missing copies are caught after the fact.

// File: rtl/fcx_pkg.sv
package fcx_pkg;

    // Header field widths fixed by the cell format
    localparam int DEST_W  = 7;
    localparam int GROUP_W = 16;

    typedef enum logic {
        CELL_UNICAST   = 1'b0,
        CELL_MULTICAST = 1'b1
    } cell_kind_e;

    typedef struct packed {
        cell_kind_e          kind;
        logic [DEST_W-1:0]   dest;
        logic [GROUP_W-1:0]  group;
    } fcx_hdr_t;

    function automatic logic group_out_of_range(input logic [GROUP_W-1:0] grp, input int depth);
        return 32'(grp) >= depth;
    endfunction

endpackage

// File: rtl/fcx_group_table.sv
module fcx_group_table
    import fcx_pkg::*;
#(
    parameter int N_IN      = 4,
    parameter int N_OUT     = 8,
    parameter int TBL_DEPTH = 256,
    parameter int TBL_AW    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [TBL_AW-1:0] wr_addr,
    input  logic [N_OUT-1:0]  wr_map,
    input  logic              rd_en   [N_IN],
    input  logic [TBL_AW-1:0] rd_addr [N_IN],
    output logic [N_OUT-1:0]  rd_map  [N_IN]
);

    logic [N_OUT-1:0] mem [TBL_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < TBL_DEPTH; e++) mem[e] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_map;
        end
    end

    // One synchronous read port per input; a same-edge write is not seen
    for (genvar i = 0; i < N_IN; i++) begin : g_rd
        always_ff @(posedge clk) begin
            if (rd_en[i]) rd_map[i] <= mem[rd_addr[i]];
        end
    end

endmodule

// File: rtl/fcx_in_head.sv
module fcx_in_head
    import fcx_pkg::*;
#(
    parameter int N_OUT     = 8,
    parameter int DATA_W    = 16,
    parameter int TBL_DEPTH = 256,
    parameter int TBL_AW    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  fcx_hdr_t          in_hdr,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              rd_en,
    output logic [TBL_AW-1:0] rd_addr,
    input  logic [N_OUT-1:0]  rd_map,
    input  logic [N_OUT-1:0]  taken,
    output logic              head_valid,
    output logic [N_OUT-1:0]  head_mask,
    output logic [DATA_W-1:0] head_data,
    output logic              drop
);

    logic              valid_q;
    logic              fresh_q;
    logic              bad_q;
    fcx_hdr_t          hdr_q;
    logic [DATA_W-1:0] data_q;
    logic [N_OUT-1:0]  pend_q;
    logic [N_OUT-1:0]  uni_map;
    logic [N_OUT-1:0]  first_map;
    logic              done;
    logic              accept;

    always_comb begin
        uni_map = '0;
        for (int j = 0; j < N_OUT; j++) uni_map[j] = (hdr_q.dest == DEST_W'(j));
        if (hdr_q.kind == CELL_MULTICAST) first_map = bad_q ? '0 : rd_map;
        else                              first_map = uni_map;
        if (!valid_q)     head_mask = '0;
        else if (fresh_q) head_mask = first_map;
        else              head_mask = pend_q;
    end

    assign done       = valid_q && ((head_mask & ~taken) == '0);
    assign drop       = valid_q && fresh_q && (head_mask == '0);
    assign in_ready   = !valid_q || done;
    assign accept     = in_valid && in_ready;
    assign rd_en      = accept;
    assign rd_addr    = in_hdr.group[TBL_AW-1:0];
    assign head_valid = valid_q;
    assign head_data  = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            fresh_q <= 1'b0;
            pend_q  <= '0;
        end else if (accept) begin
            valid_q <= 1'b1;
            fresh_q <= 1'b1;
        end else if (done) begin
            valid_q <= 1'b0;
            fresh_q <= 1'b0;
        end else if (valid_q) begin
            fresh_q <= 1'b0;
            pend_q  <= head_mask & ~taken;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            hdr_q  <= in_hdr;
            data_q <= in_data;
            bad_q  <= group_out_of_range(in_hdr.group, TBL_DEPTH);
        end
    end

    // R5: a cell with copies still owed keeps its place and payload
    p_head_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !done) |=> (valid_q && !fresh_q && $stable(data_q)));

    // R3: a destination already served is never asked for again
    p_no_dup_r3: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !done) |=> ((head_mask & $past(head_mask & taken)) == '0));

endmodule

// File: rtl/fcx_out_arb.sv
module fcx_out_arb #(
    parameter int N_IN  = 4,
    parameter int SRC_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IN-1:0]  req,
    input  logic             take,
    output logic [N_IN-1:0]  gnt,
    output logic             any,
    output logic [SRC_W-1:0] pick
);

    logic [SRC_W-1:0] ptr_q;

    always_comb begin
        logic [SRC_W-1:0] idx;
        gnt  = '0;
        any  = 1'b0;
        pick = '0;
        for (int k = 0; k < N_IN; k++) begin
            idx = SRC_W'((int'(ptr_q) + k) % N_IN);
            if (!any && take && req[idx]) begin
                gnt[idx] = 1'b1;
                any      = 1'b1;
                pick     = idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      ptr_q <= '0;
        else if (any) ptr_q <= SRC_W'((int'(pick) + 1) % N_IN);
    end

    // R6: at most one grant, and only to a requester
    p_grant_legal_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt) && ((gnt & ~req) == '0));

    // R6: a held request with the output free is not left waiting
    p_grant_work_r6: assert property (@(posedge clk) disable iff (rst)
        (take && (req != '0)) |-> any);

endmodule

// File: rtl/fcx_cell_forwarder.sv
module fcx_cell_forwarder
    import fcx_pkg::*;
#(
    parameter int N_IN      = 4,
    parameter int N_OUT     = 8,
    parameter int DATA_W    = 16,
    parameter int TBL_DEPTH = 256,
    parameter int CNT_W     = 16,
    localparam int SRC_W    = (N_IN > 1) ? $clog2(N_IN) : 1,
    localparam int TBL_AW   = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_IN-1:0]         in_valid,
    output logic [N_IN-1:0]         in_ready,
    input  logic [N_IN-1:0]         in_mcast,
    input  logic [N_IN*DEST_W-1:0]  in_dest,
    input  logic [N_IN*GROUP_W-1:0] in_group,
    input  logic [N_IN*DATA_W-1:0]  in_data,
    output logic [N_OUT-1:0]        out_valid,
    input  logic [N_OUT-1:0]        out_ready,
    output logic [N_OUT*DATA_W-1:0] out_data,
    output logic [N_OUT*SRC_W-1:0]  out_src,
    input  logic                    tbl_we,
    input  logic [TBL_AW-1:0]       tbl_addr,
    input  logic [N_OUT-1:0]        tbl_map,
    output logic [CNT_W-1:0]        drop_count
);

    fcx_hdr_t          hdr_in    [N_IN];
    logic              rd_en     [N_IN];
    logic [TBL_AW-1:0] rd_addr   [N_IN];
    logic [N_OUT-1:0]  rd_map    [N_IN];
    logic [N_OUT-1:0]  head_mask [N_IN];
    logic [DATA_W-1:0] head_data [N_IN];
    logic [N_OUT-1:0]  taken     [N_IN];
    logic [N_IN-1:0]   head_vld;
    logic [N_IN-1:0]   drop_vec;
    logic [N_IN-1:0]   req_m     [N_OUT];
    logic [N_IN-1:0]   gnt_m     [N_OUT];

    logic              out_vld_q [N_OUT];
    logic [DATA_W-1:0] out_dat_q [N_OUT];
    logic [SRC_W-1:0]  out_src_q [N_OUT];
    logic [CNT_W-1:0]  drop_q;

    fcx_group_table #(
        .N_IN(N_IN), .N_OUT(N_OUT), .TBL_DEPTH(TBL_DEPTH), .TBL_AW(TBL_AW)
    ) u_table (
        .clk(clk), .rst(rst),
        .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_map(tbl_map),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_map(rd_map)
    );

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        assign hdr_in[i] = '{kind:  cell_kind_e'(in_mcast[i]),
                             dest:  in_dest[i*DEST_W +: DEST_W],
                             group: in_group[i*GROUP_W +: GROUP_W]};

        for (genvar j = 0; j < N_OUT; j++) begin : g_tk
            assign taken[i][j] = gnt_m[j][i];
        end

        fcx_in_head #(
            .N_OUT(N_OUT), .DATA_W(DATA_W), .TBL_DEPTH(TBL_DEPTH), .TBL_AW(TBL_AW)
        ) u_head (
            .clk(clk), .rst(rst),
            .in_valid(in_valid[i]), .in_hdr(hdr_in[i]),
            .in_data(in_data[i*DATA_W +: DATA_W]), .in_ready(in_ready[i]),
            .rd_en(rd_en[i]), .rd_addr(rd_addr[i]), .rd_map(rd_map[i]),
            .taken(taken[i]),
            .head_valid(head_vld[i]), .head_mask(head_mask[i]),
            .head_data(head_data[i]), .drop(drop_vec[i])
        );
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        logic             take;
        logic             any;
        logic [SRC_W-1:0] pick;

        for (genvar i = 0; i < N_IN; i++) begin : g_rq
            assign req_m[j][i] = head_vld[i] && head_mask[i][j];
        end

        assign take = !out_vld_q[j] || out_ready[j];

        fcx_out_arb #(.N_IN(N_IN), .SRC_W(SRC_W)) u_arb (
            .clk(clk), .rst(rst), .req(req_m[j]), .take(take),
            .gnt(gnt_m[j]), .any(any), .pick(pick)
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                out_vld_q[j] <= 1'b0;
            end else if (take) begin
                out_vld_q[j] <= any;
            end
        end

        always_ff @(posedge clk) begin
            if (take && any) begin
                out_dat_q[j] <= head_data[pick];
                out_src_q[j] <= pick;
            end
        end

        assign out_valid[j]                  = out_vld_q[j];
        assign out_data[j*DATA_W +: DATA_W]  = out_dat_q[j];
        assign out_src[j*SRC_W +: SRC_W]     = out_src_q[j];

        // R8: a stalled output keeps its cell
        p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
            (out_vld_q[j] && !out_ready[j]) |=>
                (out_vld_q[j] && $stable(out_dat_q[j]) && $stable(out_src_q[j])));
    end

    always_ff @(posedge clk) begin
        if (rst) drop_q <= '0;
        else     drop_q <= drop_q + CNT_W'($countones(drop_vec));
    end

    assign drop_count = drop_q;

    // R7: the drop count never steps by more than the number of inputs
    p_drop_step_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((drop_q - $past(drop_q)) <= CNT_W'(N_IN)));

endmodule

// File: tb/fcx_cell_forwarder_bench.sv
module fcx_cell_forwarder_bench;

    localparam int N_IN = 4, N_OUT = 8, DATA_W = 16, TBL_DEPTH = 256, CNT_W = 16;
    localparam int SRC_W = 2, TBL_AW = 8;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [N_IN-1:0]         in_valid = '0;
    logic [N_IN-1:0]         in_ready;
    logic [N_IN-1:0]         in_mcast = '0;
    logic [N_IN*7-1:0]       in_dest  = '0;
    logic [N_IN*16-1:0]      in_group = '0;
    logic [N_IN*DATA_W-1:0]  in_data  = '0;
    logic [N_OUT-1:0]        out_valid;
    logic [N_OUT-1:0]        out_ready = '1;
    logic [N_OUT*DATA_W-1:0] out_data;
    logic [N_OUT*SRC_W-1:0]  out_src;
    logic                    tbl_we = 1'b0;
    logic [TBL_AW-1:0]       tbl_addr = '0;
    logic [N_OUT-1:0]        tbl_map = '0;
    logic [CNT_W-1:0]        drop_count;

    int total = 0;
    int passed = 0;
    int hs_cnt [N_OUT] = '{default: 0};
    int log6 [16] = '{default: 0};
    int log6_n = 0;

    always #10 clk = ~clk;

    fcx_cell_forwarder #(
        .N_IN(N_IN), .N_OUT(N_OUT), .DATA_W(DATA_W), .TBL_DEPTH(TBL_DEPTH), .CNT_W(CNT_W)
    ) u_fcx_cell_forwarder (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_mcast(in_mcast),
        .in_dest(in_dest), .in_group(in_group), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_src(out_src), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_map(tbl_map), .drop_count(drop_count)
    );

    // Handshake monitor
    always @(posedge clk) begin
        if (!rst) begin
            for (int j = 0; j < N_OUT; j++) begin
                if (out_valid[j] && out_ready[j]) begin
                    hs_cnt[j] = hs_cnt[j] + 1;
                    if (j == 6 && log6_n < 16) begin
                        log6[log6_n] = int'(out_src[j*SRC_W +: SRC_W]);
                        log6_n = log6_n + 1;
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (ok) passed++;
        else $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [DATA_W-1:0] odata(input int j);
        return out_data[j*DATA_W +: DATA_W];
    endfunction

    task automatic set_cell(input int i, input bit mc, input int dest, input int grp,
                            input logic [DATA_W-1:0] d);
        in_valid[i] = 1'b1;
        in_mcast[i] = mc;
        in_dest[i*7 +: 7] = 7'(dest);
        in_group[i*16 +: 16] = 16'(grp);
        in_data[i*DATA_W +: DATA_W] = d;
    endtask

    // Holds each presented cell until the edge that accepts it
    task automatic push_all();
        logic [N_IN-1:0] acc;
        for (int g = 0; g < 60 && in_valid != '0; g++) begin
            #1;
            acc = in_valid & in_ready;
            step();
            in_valid = in_valid & ~acc;
        end
    endtask

    task automatic tbl_write(input int a, input logic [N_OUT-1:0] m);
        tbl_we = 1'b1;
        tbl_addr = TBL_AW'(a);
        tbl_map = m;
        step();
        tbl_we = 1'b0;
    endtask

    task automatic t_reset();
        check(out_valid == '0, "R9 out_valid", out_valid, 0);
        check(drop_count == '0, "R9 drop_count", drop_count, 0);
        check(in_ready == '1, "R9 in_ready", in_ready, 4'hF);
    endtask

    task automatic t_unicast();
        int c;
        set_cell(0, 1'b0, 3, 77, 16'hA1A1);
        push_all();
        check(out_valid == '0, "R1 not early", out_valid, 0);
        step();
        check(out_valid == 8'h08, "R1 one output", out_valid, 8'h08);
        check(odata(3) == 16'hA1A1, "R1 data", odata(3), 16'hA1A1);
        check(out_src[3*SRC_W +: SRC_W] == 2'd0, "R1 source", out_src[3*SRC_W +: SRC_W], 0);
        step();
        c = hs_cnt[7];
        set_cell(3, 1'b0, 7, 0, 16'h0707);
        push_all();
        step();
        check(odata(7) == 16'h0707 && out_src[7*SRC_W +: SRC_W] == 2'd3,
              "R1 input 3", odata(7), 16'h0707);
        repeat (2) step();
        check(hs_cnt[7] == c + 1, "R1 single delivery", hs_cnt[7] - c, 1);
    endtask

    task automatic t_multicast();
        int base [N_OUT];
        logic [N_OUT-1:0] m = 8'hA6;
        tbl_write(5, m);
        for (int j = 0; j < N_OUT; j++) base[j] = hs_cnt[j];
        set_cell(2, 1'b1, 0, 5, 16'hB2B2);
        push_all();
        step();
        check(out_valid == m, "R2 fan-out", out_valid, m);
        check(odata(7) == 16'hB2B2 && odata(1) == 16'hB2B2, "R2 data", odata(7), 16'hB2B2);
        repeat (3) step();
        for (int j = 0; j < N_OUT; j++)
            check(hs_cnt[j] - base[j] == int'(m[j]), "R3 copy count",
                  hs_cnt[j] - base[j], m[j]);
    endtask

    task automatic t_table_timing();
        logic [CNT_W-1:0] d0 = drop_count;
        tbl_we = 1'b1;
        tbl_addr = 8'd9;
        tbl_map = 8'h02;
        set_cell(1, 1'b1, 0, 9, 16'hC9C9);
        push_all();
        tbl_we = 1'b0;
        step();
        check(drop_count == d0 + 1, "R4 same-edge write unseen", drop_count, d0 + 1);
        check(out_valid == '0, "R4 no copy from old entry", out_valid, 0);
        set_cell(1, 1'b1, 0, 9, 16'hCACA);
        push_all();
        step();
        check(out_valid == 8'h02 && odata(1) == 16'hCACA, "R4 new entry", out_valid, 8'h02);
        repeat (2) step();
    endtask

    task automatic t_drop();
        logic [CNT_W-1:0] d0;
        tbl_write(0, 8'hFF);
        d0 = drop_count;
        set_cell(0, 1'b0, 8, 0, 16'hD8D8);
        push_all();
        step();
        check(drop_count == d0 + 1, "R7 unicast range", drop_count, d0 + 1);
        check(out_valid == '0, "R7 no copy", out_valid, 0);
        set_cell(1, 1'b0, 127, 0, 16'hD9D9);
        set_cell(2, 1'b1, 3, 256, 16'hDADA);
        push_all();
        step();
        check(drop_count == d0 + 3, "R7 two drops one edge", drop_count, d0 + 3);
        check(out_valid == '0, "R7 group range", out_valid, 0);
        check(in_ready == '1, "R7 input freed", in_ready, 4'hF);
    endtask

    task automatic t_partial();
        int b0, b4;
        out_ready[4] = 1'b0;
        set_cell(0, 1'b0, 4, 0, 16'hC0C0);
        push_all();
        step();
        check(out_valid[4] && odata(4) == 16'hC0C0, "R8 stalled load", odata(4), 16'hC0C0);
        step();
        check(out_valid[4] && odata(4) == 16'hC0C0, "R8 held", odata(4), 16'hC0C0);
        tbl_write(6, 8'h11);
        b0 = hs_cnt[0];
        b4 = hs_cnt[4];
        set_cell(1, 1'b1, 0, 6, 16'hC1C1);
        push_all();
        step();
        check(out_valid[0] && odata(0) == 16'hC1C1, "R5 early copy", odata(0), 16'hC1C1);
        check(in_ready[1] == 1'b0, "R5 head held", in_ready[1], 0);
        check(odata(4) == 16'hC0C0, "R8 still held", odata(4), 16'hC0C0);
        step();
        check(in_ready[1] == 1'b0, "R5 still held", in_ready[1], 0);
        out_ready[4] = 1'b1;
        #1;
        check(in_ready[1] == 1'b1, "R5 ready on last grant", in_ready[1], 1);
        step();
        check(out_valid[4] && odata(4) == 16'hC1C1, "R5 late copy", odata(4), 16'hC1C1);
        repeat (2) step();
        check(hs_cnt[0] - b0 == 1, "R3 out0 once", hs_cnt[0] - b0, 1);
        check(hs_cnt[4] - b4 == 2, "R3 out4 twice", hs_cnt[4] - b4, 2);
    endtask

    task automatic t_round_robin();
        int exp_order [4] = '{3, 0, 1, 2};
        set_cell(2, 1'b0, 6, 0, 16'hD2D2);
        push_all();
        repeat (3) step();
        for (int i = 0; i < N_IN; i++) set_cell(i, 1'b0, 6, 0, 16'hE000 + 16'(i));
        push_all();
        repeat (8) step();
        check(log6_n == 5, "R6 deliveries", log6_n, 5);
        for (int k = 0; k < 4; k++)
            check(log6[k+1] == exp_order[k], "R6 order", log6[k+1], exp_order[k]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", passed, total);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        t_reset();
        t_unicast();
        t_multicast();
        t_table_timing();
        t_drop();
        t_partial();
        t_round_robin();
        $display("%0d/%0d checks passed", passed, total);
        $finish;
    end

endmodule